// File: doc/BRIEF.md
# Bridge Memory Window Decoder

This block holds the two memory windows of a bus bridge and checks transaction addresses against them. One window covers non-prefetchable memory and the other covers prefetchable memory. Each window has a lower bound and an upper bound with 1 MB granularity. Both bounds are compared with address bits 31:20. The lower bound is inclusive and the upper bound is exclusive.

A small configuration port writes and reads each window as one 32-bit word, with per-byte enables. Requests heading downstream are decoded into one hit flag per window. They are forwarded only while memory-space decoding is enabled. Requests coming upstream from the secondary bus are claimed when they fall outside both windows, but only while bus mastering is enabled. All decode outputs are combinational from the addresses and the current register contents.

Top module: `bwin_decoder`

## Requirements
- R1: After reset, the word at offset 20h reads 00000000h and the word at offset 24h reads 00010001h.
- R2: In both window words, the lower bound lives in bits 15:4 and the upper bound lives in bits 31:20. Both fields are writable and read back as written.
- R3: A write changes only the bytes whose enable bit is set (cfg_be[n] covers bits 8n+7:8n). The other bytes keep their old value.
- R4: In the word at 20h, bits 19:16 and 3:0 always read zero, and writing them has no effect.
- R5: In the word at 24h, bits 19:16 and 3:0 always read 1h, and writing them has no effect.
- R6: dn_np_hit is 1 exactly when dn_addr[31:20] is greater than or equal to the lower bound at 20h and strictly less than the upper bound at 20h. dn_pf_hit follows the same rule using the word at 24h. When the windows overlap, both flags may be 1 at once.
- R7: A window whose lower bound is greater than or equal to its upper bound never matches.
- R8: dn_fwd is 1 exactly when mem_space_en is 1 and at least one hit flag is 1.
- R9: up_claim is 1 exactly when bus_master_en is 1 and up_addr lies outside both windows, under the same bound rule as R6.
- R10: Any offset other than 20h and 24h reads zero. A write to such an offset changes neither window.
- R11: A write takes effect on the clock edge that accepts it. Until that edge, the decode outputs reflect the old bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| mem_space_en | input | 1 | Memory-space decode enable |
| bus_master_en | input | 1 | Bus-master enable for upstream claims |
| dn_addr | input | 32 | Downstream request address |
| dn_np_hit | output | 1 | dn_addr is inside the non-prefetchable window |
| dn_pf_hit | output | 1 | dn_addr is inside the prefetchable window |
| dn_fwd | output | 1 | Forward the downstream request to the secondary bus |
| up_addr | input | 32 | Upstream request address |
| up_claim | output | 1 | Bridge claims the upstream request |

## Verification
The assertions check on every cycle that forwarding and claiming obey their enable gates, and that an empty window never produces a hit. They also check that the fixed nibbles read back as zero or 1h, and that the bounds change only when a write is accepted at a valid offset. Only the bench scenarios can show the exact match boundaries. These are the inclusive lower edge and the exclusive upper edge, byte-enable merging, overlapping windows, the one-cycle timing of a write, and the claim results for specific addresses.

// File: rtl/bwin_pkg.sv
package bwin_pkg;
  localparam int ADDR_W     = 32;
  localparam int GRAN_SHIFT = 20;
  localparam int FW         = ADDR_W - GRAN_SHIFT;
  localparam int NIB_W      = 4;
  localparam int CFG_AW     = 8;
  localparam int BE_W       = ADDR_W / 8;

  typedef logic [FW-1:0]     bound_t;
  typedef logic [ADDR_W-1:0] word_t;

  typedef struct packed {
    bound_t lo;
    bound_t hi;
  } window_t;

  // Inclusive lower bound, exclusive upper bound on the top address bits.
  function automatic logic in_window(input word_t addr, input window_t w);
    bound_t top;
    top = addr[ADDR_W-1:GRAN_SHIFT];
    return (top >= w.lo) && (top < w.hi);
  endfunction

  function automatic word_t be_mask(input logic [BE_W-1:0] be);
    word_t m;
    for (int i = 0; i < BE_W; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic word_t pack_word(input window_t w, input logic [NIB_W-1:0] fixed);
    return {w.hi, fixed, w.lo, fixed};
  endfunction

  function automatic window_t unpack_word(input word_t d);
    window_t w;
    w.hi = d[ADDR_W-1 -: FW];
    w.lo = d[NIB_W +: FW];
    return w;
  endfunction
endpackage

// File: rtl/bwin_window_reg.sv
module bwin_window_reg
  import bwin_pkg::*;
#(
  parameter logic [NIB_W-1:0] FIXED_NIB = '0,
  parameter bound_t           RST_LO    = '0,
  parameter bound_t           RST_HI    = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [BE_W-1:0] be,
  input  word_t           wdata,
  output window_t         win,
  output word_t           rword
);
  word_t   merged;
  window_t next_win;

  always_comb begin
    merged   = (pack_word(win, FIXED_NIB) & ~be_mask(be)) | (wdata & be_mask(be));
    next_win = unpack_word(merged);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win.lo <= RST_LO;
      win.hi <= RST_HI;
    end else if (wr_en) begin
      win <= next_win;
    end
  end

  assign rword = pack_word(win, FIXED_NIB);
endmodule

// File: rtl/bwin_window_cmp.sv
module bwin_window_cmp
  import bwin_pkg::*;
#(
  parameter int N_WIN = 2
) (
  input  word_t            addr,
  input  window_t          wins [N_WIN],
  output logic [N_WIN-1:0] hit
);
  for (genvar g = 0; g < N_WIN; g++) begin : g_cmp
    assign hit[g] = in_window(addr, wins[g]);
  end
endmodule

// File: rtl/bwin_decoder.sv
module bwin_decoder
  import bwin_pkg::*;
#(
  parameter logic [CFG_AW-1:0] NP_OFF = 8'h20,
  parameter logic [CFG_AW-1:0] PF_OFF = 8'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [BE_W-1:0]   cfg_be,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              mem_space_en,
  input  logic              bus_master_en,
  input  logic [ADDR_W-1:0] dn_addr,
  output logic              dn_np_hit,
  output logic              dn_pf_hit,
  output logic              dn_fwd,
  input  logic [ADDR_W-1:0] up_addr,
  output logic              up_claim
);
  localparam int N_WIN = 2;
  localparam int NP = 0;
  localparam int PF = 1;

  // Named internal events, used by the bound checker.
  logic    sel_np, sel_pf;
  logic    wr_np, wr_pf;
  window_t wins [N_WIN];
  word_t   np_word, pf_word;
  bound_t  np_lo, np_hi, pf_lo, pf_hi;
  logic [N_WIN-1:0] dn_hits, up_hits;

  assign sel_np = (cfg_addr == NP_OFF);
  assign sel_pf = (cfg_addr == PF_OFF);
  assign wr_np  = cfg_wr && sel_np;
  assign wr_pf  = cfg_wr && sel_pf;

  bwin_window_reg #(.FIXED_NIB(4'h0), .RST_LO('0), .RST_HI('0)) u_np_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_np), .be(cfg_be), .wdata(cfg_wdata),
    .win(wins[NP]), .rword(np_word)
  );

  bwin_window_reg #(.FIXED_NIB(4'h1), .RST_LO('0), .RST_HI('0)) u_pf_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_pf), .be(cfg_be), .wdata(cfg_wdata),
    .win(wins[PF]), .rword(pf_word)
  );

  assign np_lo = wins[NP].lo;
  assign np_hi = wins[NP].hi;
  assign pf_lo = wins[PF].lo;
  assign pf_hi = wins[PF].hi;

  bwin_window_cmp #(.N_WIN(N_WIN)) u_dn_cmp (.addr(dn_addr), .wins(wins), .hit(dn_hits));
  bwin_window_cmp #(.N_WIN(N_WIN)) u_up_cmp (.addr(up_addr), .wins(wins), .hit(up_hits));

  assign dn_np_hit = dn_hits[NP];
  assign dn_pf_hit = dn_hits[PF];
  assign dn_fwd    = mem_space_en && (|dn_hits);
  assign up_claim  = bus_master_en && !(|up_hits);

  always_comb begin
    cfg_rdata = '0;
    if (sel_np)      cfg_rdata = np_word;
    else if (sel_pf) cfg_rdata = pf_word;
  end
endmodule

// File: rtl/bwin_decoder_chk.sv
module bwin_decoder_chk
  import bwin_pkg::*;
#(
  parameter logic [CFG_AW-1:0] NP_OFF = 8'h20,
  parameter logic [CFG_AW-1:0] PF_OFF = 8'h24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [ADDR_W-1:0] cfg_rdata,
  input logic              mem_space_en,
  input logic              bus_master_en,
  input logic              dn_np_hit,
  input logic              dn_pf_hit,
  input logic              dn_fwd,
  input logic              up_claim,
  input bound_t            np_lo,
  input bound_t            np_hi,
  input bound_t            pf_lo,
  input bound_t            pf_hi
);
  assert_fwd_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_fwd |-> (mem_space_en && (dn_np_hit || dn_pf_hit)));
  assert_fwd_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_space_en && (dn_np_hit || dn_pf_hit)) |-> dn_fwd);
  assert_claim_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    up_claim |-> bus_master_en);
  assert_np_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (np_lo >= np_hi) |-> !dn_np_hit);
  assert_pf_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_lo >= pf_hi) |-> !dn_pf_hit);
  assert_np_rsvd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == NP_OFF) |-> (cfg_rdata[19:16] == 4'h0 && cfg_rdata[3:0] == 4'h0));
  assert_pf_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == PF_OFF) |-> (cfg_rdata[19:16] == 4'h1 && cfg_rdata[3:0] == 4'h1));
  assert_bad_off_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr != NP_OFF && cfg_addr != PF_OFF) |-> (cfg_rdata == '0));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr || (cfg_addr != NP_OFF && cfg_addr != PF_OFF)) |=>
      ($stable(np_lo) && $stable(np_hi) && $stable(pf_lo) && $stable(pf_hi)));
endmodule

bind bwin_decoder bwin_decoder_chk #(.NP_OFF(NP_OFF), .PF_OFF(PF_OFF)) u_chk (.*);

// File: tb/test_bwin_decoder.sv
module test_bwin_decoder;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_wr = 0;
  logic [7:0]  cfg_addr = 0;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        mem_space_en = 0;
  logic        bus_master_en = 0;
  logic [31:0] dn_addr = 0;
  logic        dn_np_hit, dn_pf_hit, dn_fwd;
  logic [31:0] up_addr = 0;
  logic        up_claim;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  bwin_decoder i_bwin_decoder (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_be = be; cfg_wr = 1;
    @(posedge clk); #1;
    cfg_wr = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    cfg_addr = a; #1;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic dn(input string tag, input logic [31:0] a, input logic np, input logic pf);
    dn_addr = a; #1;
    chk({tag, " np"}, {31'b0, dn_np_hit}, {31'b0, np});
    chk({tag, " pf"}, {31'b0, dn_pf_hit}, {31'b0, pf});
  endtask

  task automatic t_reset();
    rd("R1 np reset", 8'h20, 32'h0000_0000);
    rd("R1 pf reset", 8'h24, 32'h0001_0001);
    bus_master_en = 1; up_addr = 32'h1234_5678; #1;
    chk("R9 claim after reset", {31'b0, up_claim}, 32'd1);
    dn("R7 reset empty", 32'h0000_0000, 0, 0);
  endtask

  task automatic t_layout();
    wr(8'h20, 32'h2FFF_100F, 4'hF);
    rd("R2 R4 np readback", 8'h20, 32'h2FF0_1000);
    wr(8'h24, 32'hFFFF_FFFF, 4'hF);
    rd("R5 pf readback", 8'h24, 32'hFFF1_FFF1);
    dn("R7 pf lo==hi", 32'hFFF0_0000, 0, 0);
  endtask

  task automatic t_edges();
    dn("R6 lower edge", 32'h1000_0000, 1, 0);
    dn("R6 below", 32'h0FFF_FFFF, 0, 0);
    dn("R6 last inside", 32'h2FEF_FFFF, 1, 0);
    dn("R6 upper excl", 32'h2FF0_0000, 0, 0);
    dn_addr = 32'h1800_0000; mem_space_en = 0; #1;
    chk("R8 fwd gated", {31'b0, dn_fwd}, 32'd0);
    mem_space_en = 1; #1;
    chk("R8 fwd on", {31'b0, dn_fwd}, 32'd1);
    dn_addr = 32'h3000_0000; #1;
    chk("R8 fwd miss", {31'b0, dn_fwd}, 32'd0);
  endtask

  task automatic t_bytes();
    wr(8'h20, 32'hFFFF_5500, 4'b0010);
    rd("R3 byte1 only", 8'h20, 32'h2FF0_5500);
    wr(8'h20, 32'h7700_00FF, 4'b1000);
    rd("R3 byte3 only", 8'h20, 32'h77F0_5500);
  endtask

  task automatic t_overlap();
    wr(8'h20, 32'h2000_1000, 4'hF);
    wr(8'h24, 32'h3000_1800, 4'hF);
    rd("R5 pf overlap word", 8'h24, 32'h3001_1801);
    dn("R6 overlap both", 32'h1900_0000, 1, 1);
    dn("R6 pf only", 32'h2500_0000, 0, 1);
    up_addr = 32'h1900_0000; bus_master_en = 1; #1;
    chk("R9 inside no claim", {31'b0, up_claim}, 32'd0);
    up_addr = 32'h4000_0000; #1;
    chk("R9 outside claim", {31'b0, up_claim}, 32'd1);
    bus_master_en = 0; #1;
    chk("R9 bme off", {31'b0, up_claim}, 32'd0);
  endtask

  task automatic t_bad_offset();
    wr(8'h28, 32'hFFFF_FFFF, 4'hF);
    rd("R10 bad read", 8'h28, 32'h0);
    rd("R10 np kept", 8'h20, 32'h2000_1000);
    rd("R10 pf kept", 8'h24, 32'h3001_1801);
  endtask

  task automatic t_timing();
    dn_addr = 32'h5000_0000;
    @(negedge clk);
    cfg_addr = 8'h20; cfg_wdata = 32'h6000_4000; cfg_be = 4'hF; cfg_wr = 1;
    #5;
    chk("R11 before edge", {31'b0, dn_np_hit}, 32'd0);
    @(posedge clk); #1;
    cfg_wr = 0;
    chk("R11 after edge", {31'b0, dn_np_hit}, 32'd1);
  endtask

  task automatic t_inverted();
    wr(8'h20, 32'h1000_2000, 4'hF);
    dn("R7 inverted mid", 32'h1500_0000, 0, 0);
    dn("R7 inverted hi", 32'h2500_0000, 0, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_layout();
    t_edges();
    t_bytes();
    t_overlap();
    t_bad_offset();
    t_timing();
    t_inverted();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule